// File: doc/BRIEF.md
# Window Watchdog Timer

This block watches a processor's periodic service pulses ("kicks") and raises a reset request when the software stops servicing it or services it too soon. The interval is measured in clock cycles from the last accepted kick, or from the last restart of supervision. A kick is accepted only when that interval lies between a programmable lower bound and a programmable upper bound. A loop that spins too fast is caught the same way as a stalled one.

When a fault is seen, the block drives a timeout pulse of programmable length. Two sticky flags record whether the fault was an early kick or a missing kick, so a system controller can log the event. The timeout output is only a request. Downstream logic decides whether it becomes a local reset or a power cycle. A classic mode turns off the lower bound, so that only a missing kick is a fault.

Top module: `window_watchdog`

## Requirements
- R1: In window mode, a kick edge seen d cycles after the last restart is accepted when min_gap <= d <= max_gap. An accepted kick produces no timeout and restarts the interval count, so that count is 1 on the next clock edge.
- R2: In window mode, a kick edge with d < min_gap is a fault. At that edge early_flag sets and a timeout pulse begins.
- R3: If no kick is accepted by the edge where d equals max_gap, that edge is a fault, late_flag sets and a timeout pulse begins.
- R4: With classic_mode high, min_gap is ignored. Any kick edge with d <= max_gap is accepted.
- R5: Kicks are detected on rising edges only. A kick input held high is one kick, and holding it never counts again.
- R6: After a fault edge, timeout_o is high for pulse_len cycles, and a pulse_len of 0 gives a pulse of 1 cycle. Kicks during the pulse are ignored. The count restarts at the edge where the pulse ends, so the next late fault comes pulse_len + max_gap cycles after the first fault.
- R7: early_flag and late_flag stay set until clear_flags is sampled high. A clear sampled at an edge with no new fault drops both flags at that edge.
- R8: While enable is low, no fault is raised, any timeout pulse in progress is cut short, timeout_o stays low and both flags keep their value.
- R9: A synchronous reset drives timeout_o, early_flag and late_flag low and restarts the interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Supervision on when high |
| classic_mode | input | 1 | High: only the upper bound is checked |
| min_gap | input | CNT_W | Lower bound of the kick interval, in cycles |
| max_gap | input | CNT_W | Upper bound of the kick interval, in cycles (at least 1) |
| pulse_len | input | PULSE_W | Timeout pulse length in cycles (0 acts as 1) |
| kick | input | 1 | Service input, rising-edge sensitive |
| clear_flags | input | 1 | Clears both sticky flags |
| timeout_o | output | 1 | Reset request pulse |
| early_flag | output | 1 | Sticky: a kick came before min_gap |
| late_flag | output | 1 | Sticky: no kick came by max_gap |

## Verification
The bench sweeps small lower and upper bounds against every kick delay from one cycle up to one past the upper bound, in both modes, for three pulse lengths, and with the kick both pulsed and held. The cases at exactly min_gap and max_gap catch an off-by-one window: such a design would flag a legal kick as early or late, or put the timeout one cycle off. The held-kick cases catch level sensitivity, which would re-accept at once and raise an early fault. Checking where the second fault falls catches a count that does not restart at the end of the pulse, or that keeps counting through it. The disable and clear steps catch flags that are not sticky and pulses that outlive the enable.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_EARLY  = 2'd2,
    VERDICT_LATE   = 2'd3
  } verdict_e;
endpackage

// File: rtl/wwd_kick_edge.sv
module wwd_kick_edge (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic rise_o
);
  logic kick_q;

  always_ff @(posedge clk) begin
    if (rst) kick_q <= 1'b0;
    else     kick_q <= kick_i;
  end

  // One-cycle strobe on a low-to-high change of the service input
  assign rise_o = kick_i & ~kick_q;
endmodule

// File: rtl/wwd_interval_counter.sv
module wwd_interval_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // cnt_q is the number of edges since the last restart, counting the
  // current one; it saturates instead of wrapping.
  always_ff @(posedge clk) begin
    if (rst || restart_i)     cnt_q <= CNT_ONE;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;

  a_r1_restart_to_one : assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == CNT_ONE));
endmodule

// File: rtl/wwd_window_judge.sv
module wwd_window_judge
  import wwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             enable_i,
  input  logic             busy_i,
  input  logic             classic_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  output verdict_e         verdict_o
);
  logic too_soon;
  logic expired;

  assign too_soon = !classic_i && (cnt_i < min_i);
  assign expired  = (cnt_i >= max_i);

  always_comb begin
    verdict_o = VERDICT_NONE;
    if (enable_i && !busy_i) begin
      if (rise_i)       verdict_o = too_soon ? VERDICT_EARLY : VERDICT_ACCEPT;
      else if (expired) verdict_o = VERDICT_LATE;
    end
  end
endmodule

// File: rtl/wwd_fault_pulser.sv
module wwd_fault_pulser #(
  parameter int PULSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               fire_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               active_o
);
  localparam logic [PULSE_W-1:0] LEN_ONE = PULSE_W'(1);

  logic [PULSE_W-1:0] left_q;
  logic [PULSE_W-1:0] len_eff;
  logic               act_q;

  assign len_eff = (len_i == '0) ? LEN_ONE : len_i;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      left_q <= '0;
      act_q  <= 1'b0;
    end else if (fire_i) begin
      left_q <= len_eff - LEN_ONE;
      act_q  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - LEN_ONE;
      act_q  <= 1'b1;
    end else begin
      act_q  <= 1'b0;
    end
  end

  assign active_o = act_q;

  a_r6_fault_starts_pulse : assert property (@(posedge clk) disable iff (rst)
    (fire_i && enable_i) |=> act_q);
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               classic_mode,
  input  logic [CNT_W-1:0]   min_gap,
  input  logic [CNT_W-1:0]   max_gap,
  input  logic [PULSE_W-1:0] pulse_len,
  input  logic               kick,
  input  logic               clear_flags,
  output logic               timeout_o,
  output logic               early_flag,
  output logic               late_flag
);
  logic             kick_rise;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             restart;
  logic             fire;
  verdict_e         verdict;
  logic             early_q;
  logic             late_q;

  wwd_kick_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .kick_i (kick),
    .rise_o (kick_rise)
  );

  wwd_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  wwd_window_judge #(.CNT_W(CNT_W)) u_judge (
    .enable_i  (enable),
    .busy_i    (busy),
    .classic_i (classic_mode),
    .rise_i    (kick_rise),
    .cnt_i     (cnt),
    .min_i     (min_gap),
    .max_i     (max_gap),
    .verdict_o (verdict)
  );

  wwd_fault_pulser #(.PULSE_W(PULSE_W)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .enable_i (enable),
    .fire_i   (fire),
    .len_i    (pulse_len),
    .active_o (busy)
  );

  assign fire    = (verdict == VERDICT_EARLY) || (verdict == VERDICT_LATE);
  assign restart = !enable || busy || (verdict != VERDICT_NONE);

  // Sticky cause flags; a new fault takes precedence over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      if (verdict == VERDICT_EARLY) early_q <= 1'b1;
      else if (clear_flags)         early_q <= 1'b0;
      if (verdict == VERDICT_LATE)  late_q  <= 1'b1;
      else if (clear_flags)         late_q  <= 1'b0;
    end
  end

  assign timeout_o  = busy;
  assign early_flag = early_q;
  assign late_flag  = late_q;

  a_r7_early_sticky : assert property (@(posedge clk) disable iff (rst)
    (early_flag && !clear_flags) |=> early_flag);

  a_r7_late_sticky : assert property (@(posedge clk) disable iff (rst)
    (late_flag && !clear_flags) |=> late_flag);

  a_r8_off_is_quiet : assert property (@(posedge clk) disable iff (rst)
    !enable |=> !timeout_o);

  a_r4_classic_never_early : assert property (@(posedge clk) disable iff (rst)
    (classic_mode && !early_flag) |=> !early_flag);
endmodule

// File: tb/window_watchdog_test.sv
`timescale 1ns/1ps
module window_watchdog_test;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          classic_mode = 1'b0;
  logic [CW-1:0] min_gap = '0;
  logic [CW-1:0] max_gap = '0;
  logic [PW-1:0] pulse_len = '0;
  logic          kick = 1'b0;
  logic          clear_flags = 1'b0;
  logic          timeout_o, early_flag, late_flag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  window_watchdog #(.CNT_W(CW), .PULSE_W(PW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .classic_mode(classic_mode),
    .min_gap(min_gap), .max_gap(max_gap), .pulse_len(pulse_len),
    .kick(kick), .clear_flags(clear_flags), .timeout_o(timeout_o),
    .early_flag(early_flag), .late_flag(late_flag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int mn, input int mx, input bit cls,
                          input int d, input int len, input bit hold);
    int  leff  = (len == 0) ? 1 : len;
    int  span  = 2 * mx + d + leff + 4;
    bit  acc   = (d <= mx) && (cls || d >= mn);
    bit  ear   = !cls && (d < mn);
    int  exp1  = acc ? d + mx : (ear ? d : mx);
    string tag = acc ? ((cls && d < mn) ? "R4" : "R1") : (ear ? "R2" : "R3");
    int  rise1 = -1;
    int  rise2 = -1;
    int  len1  = 0;
    bit  prev  = 1'b0;
    bit  in1   = 1'b0;
    bit  ef    = 1'b0;
    bit  lf    = 1'b0;

    kick = 1'b0; clear_flags = 1'b0; enable = 1'b1; classic_mode = cls;
    min_gap = CW'(mn); max_gap = CW'(mx); pulse_len = PW'(len);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(timeout_o == 1'b0, "R9", "timeout after reset", timeout_o, 0);
    check(early_flag == 1'b0 && late_flag == 1'b0, "R9", "flags after reset",
          {early_flag, late_flag}, 0);
    rst = 1'b0;
    for (int i = 1; i <= span; i++) begin
      kick = hold ? (i >= d) : (i == d);
      @(negedge clk);
      if (timeout_o && !prev) begin
        if (rise1 < 0) begin
          rise1 = i; ef = early_flag; lf = late_flag; in1 = 1'b1;
        end else if (rise2 < 0) begin
          rise2 = i;
        end
      end
      if (!timeout_o) in1 = 1'b0;
      if (in1) len1++;
      prev = timeout_o;
    end
    check(rise1 == exp1, tag, "first timeout cycle", rise1, exp1);
    check(ef == ear, tag, "early_flag at fault", ef, ear);
    check(lf == !ear, tag, "late_flag at fault", lf, !ear);
    check(len1 == leff, "R6", "pulse length", len1, leff);
    check(rise2 == exp1 + leff + mx, hold ? "R5" : "R6", "second timeout cycle",
          rise2, exp1 + leff + mx);

    // R8: disabling drops the request and freezes the flags
    kick = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    check(timeout_o == 1'b0, "R8", "timeout when disabled", timeout_o, 0);
    repeat (mx + leff + 2) @(negedge clk);
    check(timeout_o == 1'b0, "R8", "timeout stays low disabled", timeout_o, 0);
    check(late_flag == 1'b1, "R7", "late_flag sticky", late_flag, 1);
    check(early_flag == ear, "R7", "early_flag sticky", early_flag, ear);
    clear_flags = 1'b1;
    @(negedge clk);
    clear_flags = 1'b0;
    check(early_flag == 1'b0 && late_flag == 1'b0, "R7", "flags after clear",
          {early_flag, late_flag}, 0);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int mn = 1; mn <= 3; mn++)
      for (int mx = mn; mx <= mn + 2; mx++)
        for (int cls = 0; cls <= 1; cls++)
          for (int d = 1; d <= mx + 1; d++)
            for (int li = 0; li < 3; li++)
              for (int hold = 0; hold <= 1; hold++)
                run_case(mn, mx, cls[0], d, (li == 0) ? 0 : ((li == 1) ? 1 : 3),
                         hold[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule